// File: doc/BRIEF.md
# Ping-Pong Byte Buffer with Per-Reader Bank Copies

This block carries byte data from one write clock domain into two read clock domains. All three clocks are unrelated. It holds two logical banks. The writer fills one bank while both readers read the other. When the writer stores the highest address of its bank, that bank is handed to the readers and the roles of the two banks swap. Each logical bank is kept as two physical copies, one for each reader. Every accepted write goes into both copies of the target bank at the same address in the same cycle. As a result, each storage array has one write port on the write clock and one read port on a single read clock, which is the shape a true dual-port block RAM provides.

The hand-over uses toggle handshakes. The writer flips a publish toggle when a bank is complete. Each reader passes that toggle through a two-flop synchronizer, moves to the new bank and flips its own acknowledge toggle. The writer passes both acknowledge toggles through its own synchronizers. It holds `wr_ready` low until both have matched the publish toggle, so the bank the readers just left cannot be overwritten while a read of it is still in flight.

The writer state machine has two states. `WS_FILL` (ready high) moves to `WS_WAIT_REL` when the last address is accepted. `WS_WAIT_REL` (ready low) moves back to `WS_FILL` once both acknowledgements agree with the publish toggle. Each reader state machine also has two states. `RS_EMPTY` (no bank held) moves to `RS_HOLD` on its first synchronized publish. `RS_HOLD` stays in place and updates its bank on every later publish. The storage arrays are never reset; only the control state is.

Top module: `pp_replicated_buf`

## Requirements
- R1: After reset, `wr_bank` is 0, `wr_ready` is 1, and both `rdN_valid` are 0. A read issued while a reader holds no bank returns 0.
- R2: A write accepted with `wr_en`=1, `wr_ready`=1 and `wr_addr`=DEPTH-1 (1631) flips `wr_bank` and drops `wr_ready` right after that same clock edge.
- R3: After a publish, each reader raises `rdN_valid` and sets `rdN_bank` to the bank just completed. Once raised, `rdN_valid` stays high until reset.
- R4: A read with `rdN_en`=1 at an in-range address of the held bank returns, one read-clock cycle later, the byte last written there. Both readers return identical data for the same address.
- R5: Writes offered while `wr_ready` is 0 are ignored. A write of address DEPTH-1 in that window does not flip `wr_bank`.
- R6: `wr_ready` rises again only after both readers hold the newly published bank.
- R7: A read at an address of DEPTH or above returns 0.
- R8: A write at an address of DEPTH or above is ignored and does not change `wr_bank`.
- R9: Banks alternate 0, 1, 0. Data in the bank the readers hold stays intact while the writer fills the other bank.
- R10: `rdN_data` holds its value in every cycle in which `rdN_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_rst_n | input | 1 | Active-low async reset, write control |
| wr_en | input | 1 | Write request |
| wr_addr | input | AW (11) | Write address |
| wr_data | input | WIDTH (8) | Write byte |
| wr_ready | output | 1 | Writer may fill its current bank |
| wr_bank | output | 1 | Bank the writer fills |
| rd0_clk | input | 1 | Reader 0 clock |
| rd0_rst_n | input | 1 | Active-low async reset, reader 0 control |
| rd0_en | input | 1 | Reader 0 read request |
| rd0_addr | input | AW (11) | Reader 0 address |
| rd0_data | output | WIDTH (8) | Reader 0 registered data |
| rd0_valid | output | 1 | Reader 0 holds a bank |
| rd0_bank | output | 1 | Bank held by reader 0 |
| rd1_clk | input | 1 | Reader 1 clock |
| rd1_rst_n | input | 1 | Active-low async reset, reader 1 control |
| rd1_en | input | 1 | Reader 1 read request |
| rd1_addr | input | AW (11) | Reader 1 address |
| rd1_data | output | WIDTH (8) | Reader 1 registered data |
| rd1_valid | output | 1 | Reader 1 holds a bank |
| rd1_bank | output | 1 | Bank held by reader 1 |

## Verification
The assertions check several behaviours on every cycle of their own clock domain:
- the bank flip and ready drop after a last-address write;
- that `wr_bank` stays stable while writes are refused or out of range;
- that `rdN_valid` never falls;
- the zero result for out-of-range reads;
- that read data holds while idle.

Some behaviours span clock domains or depend on stored contents, so only the bench scenarios can show them:
- that `wr_ready` returns only after both readers have switched;
- that the byte pattern read back matches what was written;
- that the held bank is undisturbed during a concurrent refill;
- that banks alternate over several fills.

// File: rtl/pp_buf_pkg.sv
package pp_buf_pkg;
    typedef enum logic {
        WS_FILL     = 1'b0,
        WS_WAIT_REL = 1'b1
    } wr_state_e;

    typedef enum logic {
        RS_EMPTY = 1'b0,
        RS_HOLD  = 1'b1
    } rd_state_e;
endpackage

// File: rtl/pp_sync2.sv
module pp_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= 1'b0;
            q    <= 1'b0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/pp_bank_ram.sv
module pp_bank_ram #(
    parameter int DEPTH = 1632,
    parameter int WIDTH = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             wclk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             rclk,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    // No reset on the array: keeps it mappable to block RAM.
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge rclk) begin
        if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/pp_write_ctrl.sv
module pp_write_ctrl
    import pp_buf_pkg::*;
#(
    parameter int DEPTH = 1632,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          ack0_async,
    input  logic          ack1_async,
    output logic          ready,
    output logic          bank,
    output logic          pub_tgl,
    output logic [1:0]    bank_we
);
    localparam logic [AW-1:0] LAST_A = AW'(DEPTH - 1);

    wr_state_e state_q, state_d;
    logic      ack0_s, ack1_s;
    logic      accept, last_wr, released;

    pp_sync2 u_sync_ack0 (.clk(clk), .rst_n(rst_n), .d(ack0_async), .q(ack0_s));
    pp_sync2 u_sync_ack1 (.clk(clk), .rst_n(rst_n), .d(ack1_async), .q(ack1_s));

    assign accept   = wr_en && (state_q == WS_FILL) && (wr_addr <= LAST_A);
    assign last_wr  = accept && (wr_addr == LAST_A);
    assign released = (ack0_s == pub_tgl) && (ack1_s == pub_tgl);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WS_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_FILL:     if (last_wr)  state_d = WS_WAIT_REL;
            WS_WAIT_REL: if (released) state_d = WS_FILL;
            default:                   state_d = WS_FILL;
        endcase
    end

    // Bank pointer and publish toggle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank    <= 1'b0;
            pub_tgl <= 1'b0;
        end else if (last_wr) begin
            bank    <= ~bank;
            pub_tgl <= ~pub_tgl;
        end
    end

    // Outputs
    always_comb begin
        ready   = 1'b0;
        bank_we = 2'b00;
        unique case (state_q)
            WS_FILL: begin
                ready         = 1'b1;
                bank_we[bank] = accept;
            end
            WS_WAIT_REL: begin
                ready = 1'b0;
            end
            default: ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/pp_read_ctrl.sv
module pp_read_ctrl
    import pp_buf_pkg::*;
#(
    parameter int DEPTH = 1632,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pub_async,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic          ack_tgl,
    output logic          valid,
    output logic          bank,
    output logic          sel_q,
    output logic          zero_q
);
    localparam logic [AW-1:0] LAST_A = AW'(DEPTH - 1);

    rd_state_e state_q, state_d;
    logic      pub_s, swap;

    pp_sync2 u_sync_pub (.clk(clk), .rst_n(rst_n), .d(pub_async), .q(pub_s));

    assign swap = (pub_s != ack_tgl);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_EMPTY: if (swap) state_d = RS_HOLD;
            RS_HOLD:            state_d = RS_HOLD;
            default:            state_d = RS_EMPTY;
        endcase
    end

    // Held bank and acknowledge: publish count parity selects the bank
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_tgl <= 1'b0;
            bank    <= 1'b0;
        end else if (swap) begin
            ack_tgl <= pub_s;
            bank    <= ~pub_s;
        end
    end

    // Read capture: bank select and zero mask travel with the RAM read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            zero_q <= 1'b1;
        end else if (rd_en) begin
            sel_q  <= bank;
            zero_q <= !((state_q == RS_HOLD) && (rd_addr <= LAST_A));
        end
    end

    // Outputs
    always_comb begin
        valid = 1'b0;
        unique case (state_q)
            RS_EMPTY: valid = 1'b0;
            RS_HOLD:  valid = 1'b1;
            default:  valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/pp_replicated_buf.sv
module pp_replicated_buf #(
    parameter int DEPTH = 1632,
    parameter int WIDTH = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             wr_clk,
    input  logic             wr_rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    output logic             wr_ready,
    output logic             wr_bank,
    input  logic             rd0_clk,
    input  logic             rd0_rst_n,
    input  logic             rd0_en,
    input  logic [AW-1:0]    rd0_addr,
    output logic [WIDTH-1:0] rd0_data,
    output logic             rd0_valid,
    output logic             rd0_bank,
    input  logic             rd1_clk,
    input  logic             rd1_rst_n,
    input  logic             rd1_en,
    input  logic [AW-1:0]    rd1_addr,
    output logic [WIDTH-1:0] rd1_data,
    output logic             rd1_valid,
    output logic             rd1_bank
);
    localparam int NRD  = 2;
    localparam int NBNK = 2;

    logic             pub_tgl;
    logic [NBNK-1:0]  bank_we;
    logic [NRD-1:0]   rclk, rrst_n, ren, ack, rvalid, rbank, sel_q, zero_q;
    logic [AW-1:0]    raddr [NRD];
    logic [WIDTH-1:0] rdata [NRD];
    logic [WIDTH-1:0] ram_q [NRD][NBNK];

    assign rclk   = {rd1_clk, rd0_clk};
    assign rrst_n = {rd1_rst_n, rd0_rst_n};
    assign ren    = {rd1_en, rd0_en};
    assign raddr[0] = rd0_addr;
    assign raddr[1] = rd1_addr;

    pp_write_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_wctrl (
        .clk(wr_clk), .rst_n(wr_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .ack0_async(ack[0]), .ack1_async(ack[1]),
        .ready(wr_ready), .bank(wr_bank), .pub_tgl(pub_tgl), .bank_we(bank_we)
    );

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        pp_read_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_rctrl (
            .clk(rclk[r]), .rst_n(rrst_n[r]), .pub_async(pub_tgl),
            .rd_en(ren[r]), .rd_addr(raddr[r]), .ack_tgl(ack[r]),
            .valid(rvalid[r]), .bank(rbank[r]), .sel_q(sel_q[r]), .zero_q(zero_q[r])
        );

        for (genvar b = 0; b < NBNK; b++) begin : g_bank
            pp_bank_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_ram (
                .wclk(wr_clk), .we(bank_we[b]), .waddr(wr_addr), .wdata(wr_data),
                .rclk(rclk[r]), .re(ren[r]), .raddr(raddr[r]), .rdata(ram_q[r][b])
            );
        end

        assign rdata[r] = zero_q[r] ? '0 : ram_q[r][sel_q[r]];
    end

    assign rd0_data  = rdata[0];
    assign rd1_data  = rdata[1];
    assign rd0_valid = rvalid[0];
    assign rd1_valid = rvalid[1];
    assign rd0_bank  = rbank[0];
    assign rd1_bank  = rbank[1];
endmodule

// File: rtl/pp_replicated_buf_checker.sv
module pp_replicated_buf_checker #(
    parameter int DEPTH = 1632,
    parameter int WIDTH = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input logic             wr_clk,
    input logic             wr_rst_n,
    input logic             wr_en,
    input logic [AW-1:0]    wr_addr,
    input logic             wr_ready,
    input logic             wr_bank,
    input logic             rd0_clk,
    input logic             rd0_rst_n,
    input logic             rd0_en,
    input logic [AW-1:0]    rd0_addr,
    input logic [WIDTH-1:0] rd0_data,
    input logic             rd0_valid,
    input logic             rd1_clk,
    input logic             rd1_rst_n,
    input logic             rd1_en,
    input logic [AW-1:0]    rd1_addr,
    input logic [WIDTH-1:0] rd1_data,
    input logic             rd1_valid
);
    localparam logic [AW-1:0] LAST_A = AW'(DEPTH - 1);

    assert_publish_flip_R2: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_en && wr_ready && wr_addr == LAST_A) |=> (wr_bank != $past(wr_bank)) && !wr_ready);

    assert_refused_write_R5: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        !wr_ready |=> $stable(wr_bank));

    assert_oob_write_R8: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_en && wr_addr > LAST_A) |=> $stable(wr_bank));

    assert_valid_sticky0_R3: assert property (@(posedge rd0_clk) disable iff (!rd0_rst_n)
        rd0_valid |=> rd0_valid);

    assert_valid_sticky1_R3: assert property (@(posedge rd1_clk) disable iff (!rd1_rst_n)
        rd1_valid |=> rd1_valid);

    assert_oob_read0_R7: assert property (@(posedge rd0_clk) disable iff (!rd0_rst_n)
        (rd0_en && rd0_addr > LAST_A) |=> (rd0_data == '0));

    assert_oob_read1_R7: assert property (@(posedge rd1_clk) disable iff (!rd1_rst_n)
        (rd1_en && rd1_addr > LAST_A) |=> (rd1_data == '0));

    assert_hold0_R10: assert property (@(posedge rd0_clk) disable iff (!rd0_rst_n)
        !rd0_en |=> $stable(rd0_data));

    assert_hold1_R10: assert property (@(posedge rd1_clk) disable iff (!rd1_rst_n)
        !rd1_en |=> $stable(rd1_data));
endmodule

bind pp_replicated_buf pp_replicated_buf_checker #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_checker (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_ready(wr_ready), .wr_bank(wr_bank),
    .rd0_clk(rd0_clk), .rd0_rst_n(rd0_rst_n), .rd0_en(rd0_en), .rd0_addr(rd0_addr),
    .rd0_data(rd0_data), .rd0_valid(rd0_valid),
    .rd1_clk(rd1_clk), .rd1_rst_n(rd1_rst_n), .rd1_en(rd1_en), .rd1_addr(rd1_addr),
    .rd1_data(rd1_data), .rd1_valid(rd1_valid)
);

// File: tb/pp_replicated_buf_bench.sv
`timescale 1ns/1ps
module pp_replicated_buf_bench;
    localparam int DEPTH = 1632;
    localparam int WIDTH = 8;
    localparam int AW    = $clog2(DEPTH);

    logic wr_clk = 1'b0, rd0_clk = 1'b0, rd1_clk = 1'b0;
    logic wr_rst_n = 1'b0, rd0_rst_n = 1'b0, rd1_rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [AW-1:0]    wr_addr = '0;
    logic [WIDTH-1:0] wr_data = '0;
    logic             wr_ready, wr_bank;
    logic             rd0_en = 1'b0, rd1_en = 1'b0;
    logic [AW-1:0]    rd0_addr = '0, rd1_addr = '0;
    logic [WIDTH-1:0] rd0_data, rd1_data;
    logic             rd0_valid, rd1_valid, rd0_bank, rd1_bank;

    always #2.0  wr_clk  = ~wr_clk;   // 250 MHz
    always #2.9  rd0_clk = ~rd0_clk;
    always #3.65 rd1_clk = ~rd1_clk;

    pp_replicated_buf #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_pp_replicated_buf (.*);

    // Behavioural reference model
    logic [7:0] model [2][DEPTH];
    int  wr_tgt   = 0;   // bank the writer fills
    int  pub_bank = 0;   // bank most recently completed
    bit  pub_any  = 0;   // some bank has been completed
    bit  wr_open  = 1;   // writer expected to be ready

    int n_vec = 0, n_bad = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int a);
        return 8'((a * 37 + seed * 91 + (a >> 4)) ^ (seed * 5));
    endfunction

    function automatic int exp_rd(input int a);
        if (!pub_any || a >= DEPTH) return 0;
        return int'(model[pub_bank][a]);
    endfunction

    task automatic fill(input int seed);
        chk(wr_ready == wr_open, "R5 ready before fill", int'(wr_ready), int'(wr_open));
        for (int a = 0; a < DEPTH; a++) begin
            @(posedge wr_clk); #1;
            wr_en = 1'b1; wr_addr = AW'(a); wr_data = pat(seed, a);
            if (wr_open) begin
                model[wr_tgt][a] = pat(seed, a);
                if (a == DEPTH - 1) begin
                    wr_open  = 0;
                    pub_bank = wr_tgt;
                    pub_any  = 1;
                    wr_tgt   = 1 - wr_tgt;
                end
            end
        end
        @(posedge wr_clk); #1;
        wr_en = 1'b0;
        chk(wr_bank == wr_tgt[0], "R2 bank flip", int'(wr_bank), wr_tgt);
        chk(wr_ready == 1'b0, "R2 ready drop", int'(wr_ready), 0);
    endtask

    task automatic wait_pub;
        int n = 0;
        while (!wr_ready && n < 400) begin
            @(negedge wr_clk);
            n++;
        end
        chk(wr_ready == 1'b1, "R6 ready returns", int'(wr_ready), 1);
        chk(rd0_valid && rd0_bank == pub_bank[0], "R6/R3 reader0 switched", int'(rd0_bank), pub_bank);
        chk(rd1_valid && rd1_bank == pub_bank[0], "R6/R3 reader1 switched", int'(rd1_bank), pub_bank);
        chk(wr_bank == wr_tgt[0], "R5 bank kept", int'(wr_bank), wr_tgt);
        wr_open = 1;
    endtask

    // Pipelined reads with per-cycle compare, then an idle hold check (R10)
    task automatic rd_seq(input int r, input int start, input int n, input int step, input string req);
        int exp_prev = 0;
        bit pend = 0;
        for (int i = 0; i <= n; i++) begin
            if (r == 0) @(posedge rd0_clk); else @(posedge rd1_clk);
            #1;
            if (pend) begin
                if (r == 0) chk(rd0_data == 8'(exp_prev), req, int'(rd0_data), exp_prev);
                else        chk(rd1_data == 8'(exp_prev), req, int'(rd1_data), exp_prev);
            end
            if (i < n) begin
                int a = (start + i * step) % (1 << AW);
                if (r == 0) begin rd0_en = 1'b1; rd0_addr = AW'(a); end
                else        begin rd1_en = 1'b1; rd1_addr = AW'(a); end
                exp_prev = exp_rd(a);
                pend = 1;
            end else begin
                if (r == 0) rd0_en = 1'b0; else rd1_en = 1'b0;
            end
        end
        for (int k = 0; k < 3; k++) begin
            if (r == 0) @(posedge rd0_clk); else @(posedge rd1_clk);
        end
        #1;
        if (r == 0) chk(rd0_data == 8'(exp_prev), "R10 hold", int'(rd0_data), exp_prev);
        else        chk(rd1_data == 8'(exp_prev), "R10 hold", int'(rd1_data), exp_prev);
    endtask

    task automatic read_both(input int start, input int n, input int step, input string req);
        fork
            rd_seq(0, start, n, step, req);
            rd_seq(1, start, n, step, req);
        join
    endtask

    bit done = 0;

    initial begin
        #400000;
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #50;
        wr_rst_n = 1'b1; rd0_rst_n = 1'b1; rd1_rst_n = 1'b1;
        @(negedge wr_clk);
        // R1 reset state
        chk(wr_bank == 1'b0, "R1 wr_bank", int'(wr_bank), 0);
        chk(wr_ready == 1'b1, "R1 wr_ready", int'(wr_ready), 1);
        chk(!rd0_valid && !rd1_valid, "R1 readers empty", int'({rd1_valid, rd0_valid}), 0);
        read_both(5, 3, 100, "R1 read with no bank");

        // R8 out-of-range write ignored
        @(posedge wr_clk); #1;
        wr_en = 1'b1; wr_addr = AW'(1700); wr_data = 8'hA5;
        @(posedge wr_clk); #1;
        wr_en = 1'b0;
        chk(wr_bank == 1'b0, "R8 bank kept", int'(wr_bank), 0);
        chk(wr_ready == 1'b1, "R8 ready kept", int'(wr_ready), 1);

        // First fill of bank 0
        fill(1);
        // R5 refused last-address write must not publish
        @(posedge wr_clk); #1;
        wr_en = 1'b1; wr_addr = AW'(DEPTH - 1); wr_data = 8'hEE;
        @(posedge wr_clk); #1;
        wr_en = 1'b0;
        wait_pub();
        read_both(0, 40, 41, "R4 bank0 data");
        read_both(DEPTH - 2, 4, 1, "R7 edge and oob read");
        read_both(2047, 1, 1, "R7 top address read");

        // R9 refill the other bank while readers keep reading bank 0
        fork
            fill(2);
            rd_seq(0, 3, 30, 53, "R9 held bank intact r0");
            rd_seq(1, 7, 30, 47, "R9 held bank intact r1");
        join
        wait_pub();
        read_both(1, 40, 39, "R4/R9 bank1 data");

        fill(3);
        wait_pub();
        read_both(2, 40, 40, "R9 bank0 refilled data");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule